// File: doc/BRIEF.md
# Parallel LCD Power-Up Sequencer

This block programs a parallel-bus LCD controller after power-up, with no processor involved. A `start` pulse makes it walk a built-in table of entries, starting at entry 0. Each entry holds a 16-bit register field and a 16-bit value field. An ordinary entry produces two write cycles on an 8080-style 16-bit write port. The first cycle writes the register number with the register-select line low. The second writes the value with register-select high.

Two register codes act as commands and never reach the panel. The code 0x0100 makes the block pause for the number of milliseconds held in the value field. A millisecond prescaler derived from the clock-frequency parameter times the pause. Any register code of 0x0200 or above ends the run. `busy` is high for the whole run. A one-clock `done` pulse marks the end, after which a new `start` replays the table from the top.

Each write cycle keeps chip-select low for `WR_LOW_CYC + WR_HIGH_CYC` clocks, and the write strobe is low for the first `WR_LOW_CYC` of them. The defaults give a 200 ns cycle at 50 MHz. Register-select and data stay constant while chip-select is low, so they are stable across the strobe's rising edge.

Top module: `lcd_init_seq`

## Requirements
- R1: While reset is held and after it is released, `lcd_cs_n`=1, `lcd_wr_n`=1, `busy`=0 and `done`=0.
- R2: A `start` sampled high while `busy` is low raises `busy` at the next rising clock edge.
- R3: The table is, in order: (0x00E5,0x8000) (0x0000,0x0001) (0x002B,0x0010) (0x0001,0x0100) (0x0100,2) (0x0002,0x0700) (0x0003,0x1030) (0x0100,0) (0x0007,0x0133) (0x0100,1) (0x00FF,0x5555) (0x01FF,0xAAAA) (0x0200,0). Each ordinary entry is sent as the register number with `lcd_rs`=0, followed by the value with `lcd_rs`=1. The block sends nothing else, and entries go out in table order.
- R4: In every write cycle `lcd_cs_n` is low for exactly WR_LOW_CYC+WR_HIGH_CYC clocks. `lcd_wr_n` is low for exactly the first WR_LOW_CYC of them. `lcd_rs` and `lcd_db` do not change while `lcd_cs_n` is low. `lcd_wr_n` is never low while `lcd_cs_n` is high. The idle gap between consecutive writes with no pause entry in between is at most 8 clocks.
- R5: A pause entry (register 0x0100, value N>0) causes no bus write. During the pause `lcd_cs_n` stays high, and the gap before the next write lies between N*CLK_HZ/1000 and N*CLK_HZ/1000+8 clocks.
- R6: A pause entry with value 0 ends at once, and the next write follows within 8 clocks.
- R7: A register field of 0x0200 or above is not sent. It drops `busy` and raises `done` for exactly one clock at the same edge. No write happens until the next `start`. Table positions past the end read as a terminator.
- R8: `start` while `busy` is high is ignored. The run neither restarts nor repeats any write, and it produces exactly one `done`.
- R9: A `start` after `done` replays the whole table from entry 0.
- R10: Register numbers 0x00FF and 0x01FF, just below the two command codes, are sent as ordinary writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a run of the table (ignored while busy) |
| busy | output | 1 | High while the table is being run |
| done | output | 1 | One-clock pulse when the terminator is reached |
| lcd_cs_n | output | 1 | Panel chip select, active low |
| lcd_wr_n | output | 1 | Panel write strobe, active low |
| lcd_rs | output | 1 | Register select: 0 = index write, 1 = data write |
| lcd_db | output | 16 | Panel data bus |

## Verification
A wrong table pointer shows at once as a misplaced or repeated index/value pair on the bus, on the very next write after the fault. A wrong decode of the command codes makes a pause or terminator code appear as a bus write, or cuts the run short. Either way the captured write list differs at the first affected entry. A wrong prescaler or pause counter shows as a gap outside its allowed window before the write that follows the pause. A wrong write-cycle counter shows in the strobe or select width of the very next cycle.

// File: rtl/lcd_seq_pkg.sv
// Package: shared constants, types and the power-up table for the LCD
// sequencer.
// Assumes: entries are 16-bit register / 16-bit value pairs; register codes
// at or above SQ_END_CODE are terminators.
package lcd_seq_pkg;

    localparam int unsigned WORD_W      = 16;
    localparam logic [15:0] SQ_WAIT_CODE = 16'h0100;
    localparam logic [15:0] SQ_END_CODE  = 16'h0200;
    localparam int unsigned TABLE_LEN   = 13;

    typedef struct packed {
        logic [WORD_W-1:0] reg_no;
        logic [WORD_W-1:0] value;
    } init_pair_t;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_FETCH,
        SQ_SEND_IDX,
        SQ_WAIT_IDX,
        SQ_SEND_DAT,
        SQ_WAIT_DAT,
        SQ_PAUSE
    } seq_state_t;

    // Returns the table entry at idx; past the end reads as a terminator.
    function automatic init_pair_t table_pair(input int unsigned idx);
        init_pair_t p;
        case (idx)
            0:       p = '{reg_no: 16'h00E5, value: 16'h8000};
            1:       p = '{reg_no: 16'h0000, value: 16'h0001};
            2:       p = '{reg_no: 16'h002B, value: 16'h0010};
            3:       p = '{reg_no: 16'h0001, value: 16'h0100};
            4:       p = '{reg_no: SQ_WAIT_CODE, value: 16'd2};
            5:       p = '{reg_no: 16'h0002, value: 16'h0700};
            6:       p = '{reg_no: 16'h0003, value: 16'h1030};
            7:       p = '{reg_no: SQ_WAIT_CODE, value: 16'd0};
            8:       p = '{reg_no: 16'h0007, value: 16'h0133};
            9:       p = '{reg_no: SQ_WAIT_CODE, value: 16'd1};
            10:      p = '{reg_no: 16'h00FF, value: 16'h5555};
            11:      p = '{reg_no: 16'h01FF, value: 16'hAAAA};
            12:      p = '{reg_no: SQ_END_CODE, value: 16'h0000};
            default: p = '{reg_no: 16'hFFFF, value: 16'h0000};
        endcase
        return p;
    endfunction

endpackage

// File: rtl/init_table_rom.sv
// Module: init_table_rom
// Combinational ROM that returns one table pair per address.
// Assumes: ADDR_W is wide enough to reach the terminator entry; larger
// addresses return a terminator so a run can never escape the table.
module init_table_rom
    import lcd_seq_pkg::*;
#(
    parameter int unsigned ADDR_W = 4
) (
    input  logic [ADDR_W-1:0] addr,
    output init_pair_t        pair
);

    // Purpose: look up the pair for the current pointer.
    always_comb begin
        pair = table_pair(int'(addr));
    end

endmodule

// File: rtl/ms_pause_timer.sv
// Module: ms_pause_timer
// Counts down a whole number of milliseconds using a clock prescaler.
// Assumes: TICKS_PER_MS >= 1; a load of 0 leaves the timer inactive at once.
module ms_pause_timer #(
    parameter int unsigned TICKS_PER_MS = 50_000,
    parameter int unsigned MS_W         = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [MS_W-1:0] load_ms,
    output logic            active
);

    localparam int unsigned PRE_W   = $clog2(TICKS_PER_MS + 1);
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICKS_PER_MS - 1);

    logic [MS_W-1:0]  ms_left;
    logic [PRE_W-1:0] pre_cnt;

    // Purpose: load a new pause, or tick the prescaler and millisecond count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ms_left <= '0;
            pre_cnt <= '0;
        end else if (load) begin
            ms_left <= load_ms;
            pre_cnt <= '0;
        end else if (ms_left != '0) begin
            if (pre_cnt == PRE_LAST) begin
                pre_cnt <= '0;
                ms_left <= ms_left - 1'b1;
            end else begin
                pre_cnt <= pre_cnt + 1'b1;
            end
        end
    end

    // Purpose: the pause lasts while milliseconds remain.
    always_comb begin
        active = (ms_left != '0);
    end

endmodule

// File: rtl/bus_write_cycle.sv
// Module: bus_write_cycle
// Generates one 8080-style write: select low, strobe low for LOW_CYC clocks,
// strobe high for HIGH_CYC clocks with select still low, then select high.
// Assumes: LOW_CYC >= 1 and HIGH_CYC >= 1; a request is taken only when idle.
module bus_write_cycle #(
    parameter int unsigned LOW_CYC  = 5,
    parameter int unsigned HIGH_CYC = 5,
    parameter int unsigned DATA_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_rs,
    input  logic [DATA_W-1:0] req_data,
    output logic              ready,
    output logic              last,
    output logic              cs_n,
    output logic              wr_n,
    output logic              rs,
    output logic [DATA_W-1:0] db
);

    localparam int unsigned MAX_CYC = (LOW_CYC > HIGH_CYC) ? LOW_CYC : HIGH_CYC;
    localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] LOW_LOAD  = CNT_W'(LOW_CYC - 1);
    localparam logic [CNT_W-1:0] HIGH_LOAD = CNT_W'(HIGH_CYC - 1);

    typedef enum logic [1:0] { BW_IDLE, BW_LOW, BW_HIGH } bw_state_t;

    bw_state_t        st;
    logic [CNT_W-1:0] cnt;

    // Purpose: step through the strobe phases and hold bus values for the cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= BW_IDLE;
            cnt  <= '0;
            cs_n <= 1'b1;
            wr_n <= 1'b1;
            rs   <= 1'b0;
            db   <= '0;
        end else begin
            case (st)
                BW_IDLE: begin
                    if (req) begin
                        st   <= BW_LOW;
                        cnt  <= LOW_LOAD;
                        cs_n <= 1'b0;
                        wr_n <= 1'b0;
                        rs   <= req_rs;
                        db   <= req_data;
                    end
                end
                BW_LOW: begin
                    if (cnt == '0) begin
                        st   <= BW_HIGH;
                        cnt  <= HIGH_LOAD;
                        wr_n <= 1'b1;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                BW_HIGH: begin
                    if (cnt == '0) begin
                        st   <= BW_IDLE;
                        cs_n <= 1'b1;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: st <= BW_IDLE;
            endcase
        end
    end

    // Purpose: report idle and the final clock of a cycle to the sequencer.
    always_comb begin
        ready = (st == BW_IDLE);
        last  = (st == BW_HIGH) && (cnt == '0);
    end

endmodule

// File: rtl/lcd_init_seq.sv
// Module: lcd_init_seq (top)
// Runs the built-in power-up table on start: ordinary entries become an
// index write and a data write, pause entries wait whole milliseconds, and
// a terminator ends the run with a one-clock done pulse.
// Assumes: CLK_HZ is a multiple of 1000; the bus timing parameters are >= 1.
module lcd_init_seq
    import lcd_seq_pkg::*;
#(
    parameter int unsigned CLK_HZ      = 50_000_000,
    parameter int unsigned WR_LOW_CYC  = 5,
    parameter int unsigned WR_HIGH_CYC = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              busy,
    output logic              done,
    output logic              lcd_cs_n,
    output logic              lcd_wr_n,
    output logic              lcd_rs,
    output logic [WORD_W-1:0] lcd_db
);

    localparam int unsigned TICKS_PER_MS = CLK_HZ / 1000;
    localparam int unsigned PTR_W        = $clog2(TABLE_LEN + 1);

    seq_state_t        state;
    logic [PTR_W-1:0]  ptr;
    init_pair_t        cur;
    logic              is_end;
    logic              is_pause;
    logic              wr_req;
    logic              wr_req_rs;
    logic [WORD_W-1:0] wr_req_data;
    logic              wr_ready;
    logic              wr_last;
    logic              tmr_load;
    logic              tmr_active;

    init_table_rom #(
        .ADDR_W (PTR_W)
    ) u_rom (
        .addr (ptr),
        .pair (cur)
    );

    ms_pause_timer #(
        .TICKS_PER_MS (TICKS_PER_MS),
        .MS_W         (WORD_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .load_ms (cur.value),
        .active  (tmr_active)
    );

    bus_write_cycle #(
        .LOW_CYC  (WR_LOW_CYC),
        .HIGH_CYC (WR_HIGH_CYC),
        .DATA_W   (WORD_W)
    ) u_bus (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (wr_req),
        .req_rs   (wr_req_rs),
        .req_data (wr_req_data),
        .ready    (wr_ready),
        .last     (wr_last),
        .cs_n     (lcd_cs_n),
        .wr_n     (lcd_wr_n),
        .rs       (lcd_rs),
        .db       (lcd_db)
    );

    // Purpose: classify the current entry and form the write request.
    always_comb begin
        is_end      = (cur.reg_no >= SQ_END_CODE);
        is_pause    = (cur.reg_no == SQ_WAIT_CODE);
        tmr_load    = (state == SQ_FETCH) && !is_end && is_pause;
        wr_req      = (state == SQ_SEND_IDX) || (state == SQ_SEND_DAT);
        wr_req_rs   = (state == SQ_SEND_DAT);
        wr_req_data = wr_req_rs ? cur.value : cur.reg_no;
    end

    // Purpose: sequence the table, pointer, busy flag and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SQ_IDLE;
            ptr   <= '0;
            busy  <= 1'b0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                SQ_IDLE: begin
                    if (start) begin
                        ptr   <= '0;
                        busy  <= 1'b1;
                        state <= SQ_FETCH;
                    end
                end
                SQ_FETCH: begin
                    if (is_end) begin
                        busy  <= 1'b0;
                        done  <= 1'b1;
                        state <= SQ_IDLE;
                    end else if (is_pause) begin
                        ptr   <= ptr + 1'b1;
                        state <= SQ_PAUSE;
                    end else begin
                        state <= SQ_SEND_IDX;
                    end
                end
                SQ_SEND_IDX: if (wr_ready) state <= SQ_WAIT_IDX;
                SQ_WAIT_IDX: if (wr_last)  state <= SQ_SEND_DAT;
                SQ_SEND_DAT: if (wr_ready) state <= SQ_WAIT_DAT;
                SQ_WAIT_DAT: begin
                    if (wr_last) begin
                        ptr   <= ptr + 1'b1;
                        state <= SQ_FETCH;
                    end
                end
                SQ_PAUSE: if (!tmr_active) state <= SQ_FETCH;
                default: state <= SQ_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/lcd_init_seq_chk.sv
// Module: lcd_init_seq_chk
// Temporal checks on the sequencer's ports and its pause timer, bound to
// every instance of the top module.
// Assumes: synchronous active-low reset; all checks are off during reset.
module lcd_init_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        busy,
    input logic        done,
    input logic        cs_n,
    input logic        wr_n,
    input logic        rs,
    input logic [15:0] db,
    input logic        pause_active
);

    // R4: the strobe only falls inside a selected cycle
    a_r4_strobe_in_select: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> !cs_n);

    // R4: bus values hold while the panel is selected
    a_r4_bus_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && $past(!cs_n)) |-> ($stable(db) && $stable(rs)));

    // R2: an idle start is taken at the next edge
    a_r2_start_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R7: done lasts one clock
    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: done coincides with busy low
    a_r7_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R5: the bus is quiet throughout a pause
    a_r5_quiet_pause: assert property (@(posedge clk) disable iff (!rst_n)
        pause_active |-> (cs_n && wr_n));

endmodule

bind lcd_init_seq lcd_init_seq_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .busy         (busy),
    .done         (done),
    .cs_n         (lcd_cs_n),
    .wr_n         (lcd_wr_n),
    .rs           (lcd_rs),
    .db           (lcd_db),
    .pause_active (tmr_active)
);

// File: tb/tb_lcd_init_seq.sv
module tb_lcd_init_seq;

    localparam int unsigned CLK_HZ = 200_000;
    localparam int unsigned TPM    = CLK_HZ / 1000;
    localparam int unsigned WLOW   = 5;
    localparam int unsigned WHIGH  = 5;
    localparam int unsigned SLACK  = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        busy, done, lcd_cs_n, lcd_wr_n, lcd_rs;
    logic [15:0] lcd_db;

    int nchecks = 0;
    int nfails  = 0;
    int cyc     = 0;

    always #10 clk = ~clk;

    lcd_init_seq #(
        .CLK_HZ      (CLK_HZ),
        .WR_LOW_CYC  (WLOW),
        .WR_HIGH_CYC (WHIGH)
    ) dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .busy     (busy),
        .done     (done),
        .lcd_cs_n (lcd_cs_n),
        .lcd_wr_n (lcd_wr_n),
        .lcd_rs   (lcd_rs),
        .lcd_db   (lcd_db)
    );

    function automatic void check(input bit ok, input string req, input string what,
                                  input int act, input int exp);
        nchecks++;
        if (!ok) begin
            nfails++;
            $display("FAIL %s %s act=0x%0h exp=0x%0h", req, what, act, exp);
        end
    endfunction

    // Table as given in R3.
    function automatic logic [31:0] tb_pair(input int i);
        case (i)
            0:  return {16'h00E5, 16'h8000};
            1:  return {16'h0000, 16'h0001};
            2:  return {16'h002B, 16'h0010};
            3:  return {16'h0001, 16'h0100};
            4:  return {16'h0100, 16'd2};
            5:  return {16'h0002, 16'h0700};
            6:  return {16'h0003, 16'h1030};
            7:  return {16'h0100, 16'd0};
            8:  return {16'h0007, 16'h0133};
            9:  return {16'h0100, 16'd1};
            10: return {16'h00FF, 16'h5555};
            11: return {16'h01FF, 16'hAAAA};
            default: return {16'h0200, 16'h0000};
        endcase
    endfunction

    int          exp_n = 0;
    logic        exp_rs  [64];
    logic [15:0] exp_db  [64];
    int          exp_dly [64];
    bit          exp_zero[64];

    task automatic build_expected();
        int acc = 0;
        bit zero = 0;
        for (int i = 0; i < 64; i++) begin
            logic [31:0] p = tb_pair(i);
            if (p[31:16] >= 16'h0200) break;
            if (p[31:16] == 16'h0100) begin
                acc += int'(p[15:0]);
                if (p[15:0] == 16'd0) zero = 1;
            end else begin
                exp_rs[exp_n] = 1'b0; exp_db[exp_n] = p[31:16];
                exp_dly[exp_n] = acc; exp_zero[exp_n] = zero; exp_n++;
                exp_rs[exp_n] = 1'b1; exp_db[exp_n] = p[15:0];
                exp_dly[exp_n] = 0; exp_zero[exp_n] = 0; exp_n++;
                acc = 0; zero = 0;
            end
        end
    endtask

    // Bus monitor state
    int          ncap = 0;
    logic        cap_rs [64];
    logic [15:0] cap_db [64];
    int          cap_gap[64];
    int          done_cnt = 0;
    int          gap_cnt = 0, low_cnt = 0, cs_cnt = 0;
    logic        prev_wr = 1'b1, prev_cs = 1'b1, prev_busy = 1'b0;
    logic        fall_rs = 1'b0;
    logic [15:0] fall_db = '0;

    // Monitor: capture writes and measure strobe, select and gap widths.
    always @(negedge clk) begin
        if (!rst_n) begin
            ncap = 0; done_cnt = 0; gap_cnt = 0; low_cnt = 0; cs_cnt = 0;
            prev_wr = 1'b1; prev_cs = 1'b1; prev_busy = 1'b0;
        end else begin
            if (busy && !prev_busy) begin
                ncap = 0; done_cnt = 0; gap_cnt = 0;
            end
            if (done) done_cnt++;
            if (lcd_cs_n) gap_cnt++;
            if (prev_cs && !lcd_cs_n) begin
                if (ncap < 64) cap_gap[ncap] = gap_cnt;
                gap_cnt = 0; cs_cnt = 0;
                fall_rs = lcd_rs; fall_db = lcd_db;
            end
            if (!lcd_cs_n) cs_cnt++;
            if (!lcd_wr_n) low_cnt++;
            if (!prev_wr && lcd_wr_n) begin
                check(low_cnt == WLOW, "R4", "strobe low width", low_cnt, WLOW);
                check(!lcd_cs_n, "R4", "select low at strobe rise", lcd_cs_n, 0);
                check(lcd_db == fall_db && lcd_rs == fall_rs, "R4", "bus held in cycle",
                      lcd_db, fall_db);
                if (ncap < 64) begin
                    cap_rs[ncap] = lcd_rs; cap_db[ncap] = lcd_db;
                end
                ncap++;
                low_cnt = 0;
            end
            if (!prev_cs && lcd_cs_n) begin
                check(cs_cnt == WLOW + WHIGH, "R4", "select low width", cs_cnt, WLOW + WHIGH);
            end
            prev_wr = lcd_wr_n; prev_cs = lcd_cs_n; prev_busy = busy;
        end
    end

    // Watchdog: a hung run is counted as a failure and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            check(0, "R2", "watchdog expired", cyc, 150000);
            $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfails);
            $finish;
        end
    end

    task automatic check_reset_state(input string tag);
        check(lcd_cs_n == 1'b1 && lcd_wr_n == 1'b1, "R1", {tag, " bus idle"},
              {lcd_cs_n, lcd_wr_n}, 2'b11);
        check(!busy && !done, "R1", {tag, " busy/done low"}, {busy, done}, 0);
    endtask

    // One run: start, optional spurious or held start while busy, then verify.
    task automatic run_seq(input int spur_pct, input bit hold, input int abort_at,
                           input string tag);
        int waited = 0;
        repeat ($urandom_range(20)) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        check(busy == 1'b1, "R2", {tag, " busy after start"}, busy, 1);
        start = hold;
        while (!done) begin
            @(negedge clk);
            waited++;
            if (abort_at > 0 && waited == abort_at) begin
                rst_n = 1'b0; start = 1'b0;
                repeat (3) @(negedge clk);
                check_reset_state({tag, " mid-run reset"});
                rst_n = 1'b1;
                @(negedge clk);
                return;
            end
            if (waited > 6000) begin
                check(0, "R7", {tag, " run never ended"}, waited, 6000);
                start = 1'b0;
                return;
            end
            if (!done) start = hold | ($urandom_range(99) < spur_pct);
        end
        start = 1'b0;
        check(!busy, "R7", {tag, " busy low with done"}, busy, 0);
        repeat (2) @(negedge clk);
        check(ncap == exp_n, "R3", {tag, " write count"}, ncap, exp_n);
        check(done_cnt == 1, "R8", {tag, " exactly one done"}, done_cnt, 1);
        for (int k = 0; k < exp_n && k < ncap; k++) begin
            if (!exp_rs[k] && (exp_db[k] == 16'h00FF || exp_db[k] == 16'h01FF))
                check(cap_db[k] == exp_db[k] && cap_rs[k] == 1'b0, "R10",
                      {tag, " near-code index sent"}, cap_db[k], exp_db[k]);
            check(cap_rs[k] == exp_rs[k] && cap_db[k] == exp_db[k], "R3",
                  {tag, " write content"}, {cap_rs[k], cap_db[k]}, {exp_rs[k], exp_db[k]});
            if (exp_dly[k] > 0)
                check(cap_gap[k] >= exp_dly[k] * TPM && cap_gap[k] <= exp_dly[k] * TPM + SLACK,
                      "R5", {tag, " pause gap"}, cap_gap[k], exp_dly[k] * TPM);
            else if (exp_zero[k])
                check(cap_gap[k] <= SLACK, "R6", {tag, " zero pause gap"}, cap_gap[k], SLACK);
            else
                check(cap_gap[k] <= SLACK, "R4", {tag, " write gap"}, cap_gap[k], SLACK);
        end
        repeat (20) @(negedge clk);
        check(ncap == exp_n && lcd_cs_n && !busy, "R7", {tag, " quiet after end"}, ncap, exp_n);
    endtask

    initial begin
        void'($urandom(32'd7391));
        build_expected();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check_reset_state("in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_reset_state("after reset");
        run_seq(0, 1'b0, 0, "plain run");
        run_seq(0, 1'b0, 0, "R9 replay");
        run_seq(15, 1'b0, 0, "R8 spurious starts");
        run_seq(0, 1'b1, 0, "R8 held start");
        run_seq(0, 1'b0, 100 + int'($urandom_range(300)), "abort");
        run_seq(30, 1'b0, 0, "R9 after abort");
        for (int r = 0; r < 3; r++) run_seq(int'($urandom_range(40)), 1'b0, 0, "random");
        $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfails);
        $finish;
    end

endmodule